// File: doc/BRIEF.md
# Fully associative address translation buffer

This block turns 32-bit virtual addresses into 24-bit physical addresses for a paged memory system with 1 KB pages. It holds a parameterised number of translations, 64 by default. On every lookup it compares the 22-bit virtual page number against all resident entries in parallel. A hit returns the stored 14-bit physical page number with the 10 untranslated offset bits appended below it. A miss is flagged so that an outside handler can walk the page table and load the missing translation.

When a translation is loaded, a free slot is taken first. If there is none, the slot touched least recently, by either a hit or a load, is overwritten. When a valid entry is overwritten, the block reports that entry's page numbers and its dirty flag. A write access that hits marks its entry dirty, so the handler knows which page-table entries need updating. A flush empties the whole buffer when the process changes. A per-page invalidate removes the translation of a page that has been swapped out of main memory.

The handler must never load a virtual page that is already resident.

Top module: `xlat_buf`

## Requirements
- R1: After reset no entry is valid, rsp_valid and ev_valid are low, and every lookup misses.
- R2: A lookup presented on lk_req is answered on the rsp_* outputs one clock later, with rsp_valid high. It hits when a valid entry holds vpn = lk_va[31:10], and rsp_pa is then {ppn, lk_va[9:0]}, with the ppn in rsp_pa[23:10].
- R3: A lookup that finds no valid matching entry returns rsp_miss high, rsp_hit low and rsp_pa zero. rsp_hit and rsp_miss are never high together.
- R4: A refill (fill_req) writes fill_vpn/fill_ppn into an entry, marks it valid and clears its dirty flag. If any entry is invalid, the lowest-numbered invalid entry is used and no eviction is reported.
- R5: With every entry valid, a refill overwrites the entry least recently touched by a hit or a refill. One clock later, ev_valid pulses with that entry's old vpn and ppn.
- R6: A hitting lookup with lk_wr high sets the entry's dirty flag, and a read hit leaves it unchanged. ev_dirty carries the victim's flag at eviction.
- R7: flush invalidates every entry. In the same cycle it takes priority over refill and invalidate.
- R8: inv_req clears the valid flag of the entry matching inv_vpn. A vpn that matches no entry has no effect.
- R9: A lookup in the same cycle as a refill, invalidate or flush sees the entries as they were before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_wr | input | 1 | Lookup is a write access |
| lk_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Translation absent |
| rsp_pa | output | 24 | Translated physical address |
| fill_req | input | 1 | Load a translation |
| fill_vpn | input | 22 | Virtual page number to load |
| fill_ppn | input | 14 | Physical page number to load |
| inv_req | input | 1 | Invalidate one page |
| inv_vpn | input | 22 | Virtual page number to invalidate |
| flush | input | 1 | Invalidate every entry |
| ev_valid | output | 1 | A valid entry was overwritten |
| ev_dirty | output | 1 | Overwritten entry was dirty |
| ev_vpn | output | 22 | Overwritten entry's virtual page |
| ev_ppn | output | 14 | Overwritten entry's physical page |

## Verification
Lookup answers and eviction reports are each one register stage deep. They appear after the clock edge that accepts the request. Dirty, valid and age updates take effect at that same edge, so a lookup one cycle later sees them. The bench drives each request on a falling edge and samples its result on the next falling edge, exactly one rising edge later. The dirty flag is not visible at the ports, so it is checked only through the ev_dirty value of a later eviction.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  // where a refill lands
  typedef enum logic {
    SRC_FREE = 1'b0,
    SRC_LRU  = 1'b1
  } vic_src_e;
endpackage

// File: rtl/xlat_match.sv
// Parallel compare of one key against every stored tag.
module xlat_match #(
  parameter int N = 64,
  parameter int W = 22
) (
  input  logic [N-1:0] valid,
  input  logic [W-1:0] tags [N],
  input  logic [W-1:0] key,
  output logic [N-1:0] vec
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign vec[g] = valid[g] && (tags[g] == key);
  end
endmodule

// File: rtl/xlat_enc.sv
// One-hot (or zero) vector to index plus any-bit flag.
module xlat_enc #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/xlat_age.sv
// Recency ranks: 0 = most recent, N-1 = least recent. Ranks stay a permutation.
module xlat_age #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] lru_idx
);
  logic [IW-1:0] age_q [N];

  always_comb begin
    lru_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (age_q[i] == IW'(N - 1)) lru_idx = IW'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx)           age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/xlat_victim.sv
// Lowest free slot wins; otherwise the least recent slot.
module xlat_victim
  import xlat_pkg::*;
#(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  valid,
  input  logic [IW-1:0] lru_idx,
  output logic [IW-1:0] vic_idx,
  output vic_src_e      vic_src
);
  logic          free_any;
  logic [IW-1:0] free_idx;

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_any = 1'b1;
        free_idx = IW'(i);
      end
    end
    vic_src = free_any ? SRC_FREE : SRC_LRU;
    vic_idx = free_any ? free_idx : lru_idx;
  end
endmodule

// File: rtl/xlat_buf.sv
module xlat_buf
  import xlat_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 24,
  parameter int OFS_W   = 10,
  parameter int ENTRIES = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lk_req,
  input  logic                     lk_wr,
  input  logic [VA_W-1:0]          lk_va,
  output logic                     rsp_valid,
  output logic                     rsp_hit,
  output logic                     rsp_miss,
  output logic [PA_W-1:0]          rsp_pa,
  input  logic                     fill_req,
  input  logic [VA_W-OFS_W-1:0]    fill_vpn,
  input  logic [PA_W-OFS_W-1:0]    fill_ppn,
  input  logic                     inv_req,
  input  logic [VA_W-OFS_W-1:0]    inv_vpn,
  input  logic                     flush,
  output logic                     ev_valid,
  output logic                     ev_dirty,
  output logic [VA_W-OFS_W-1:0]    ev_vpn,
  output logic [PA_W-OFS_W-1:0]    ev_ppn
);
  localparam int VPN_W = VA_W - OFS_W;
  localparam int PPN_W = PA_W - OFS_W;
  localparam int IW    = $clog2(ENTRIES);

  function automatic logic [PA_W-1:0] join_pa(input logic [PPN_W-1:0] ppn,
                                               input logic [OFS_W-1:0] ofs);
    return {ppn, ofs};
  endfunction

  // entry storage
  logic [ENTRIES-1:0] valid_q, valid_n;
  logic [ENTRIES-1:0] dirty_q, dirty_n;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];

  // named internal events
  logic [VPN_W-1:0]   lk_vpn;
  logic [ENTRIES-1:0] lk_vec, inv_vec;
  logic               lk_any;
  logic [IW-1:0]      lk_idx;
  logic [IW-1:0]      lru_idx, vic_idx;
  vic_src_e           vic_src;
  logic               do_fill, hit_ev, wr_hit_ev, evict_ev, touch;
  logic [IW-1:0]      touch_idx;

  assign lk_vpn = lk_va[VA_W-1:OFS_W];

  xlat_match #(.N(ENTRIES), .W(VPN_W)) u_lk_match (
    .valid(valid_q), .tags(vpn_q), .key(lk_vpn), .vec(lk_vec)
  );

  xlat_match #(.N(ENTRIES), .W(VPN_W)) u_inv_match (
    .valid(valid_q), .tags(vpn_q), .key(inv_vpn), .vec(inv_vec)
  );

  xlat_enc #(.N(ENTRIES), .IW(IW)) u_lk_enc (
    .vec(lk_vec), .any(lk_any), .idx(lk_idx)
  );

  xlat_victim #(.N(ENTRIES), .IW(IW)) u_victim (
    .valid(valid_q), .lru_idx(lru_idx), .vic_idx(vic_idx), .vic_src(vic_src)
  );

  assign do_fill   = fill_req && !flush;
  assign hit_ev    = lk_req && lk_any;
  assign wr_hit_ev = hit_ev && lk_wr;
  assign evict_ev  = do_fill && (vic_src == SRC_LRU);
  assign touch     = do_fill || hit_ev;
  assign touch_idx = do_fill ? vic_idx : lk_idx;

  xlat_age #(.N(ENTRIES), .IW(IW)) u_age (
    .clk(clk), .rst_n(rst_n), .touch(touch), .touch_idx(touch_idx), .lru_idx(lru_idx)
  );

  // next-state of flags: invalidate, then refill, then flush overrides
  always_comb begin
    valid_n = valid_q;
    dirty_n = dirty_q;
    if (inv_req)   valid_n = valid_n & ~inv_vec;
    if (wr_hit_ev) dirty_n[lk_idx] = 1'b1;
    if (do_fill) begin
      valid_n[vic_idx] = 1'b1;
      dirty_n[vic_idx] = 1'b0;
    end
    if (flush)     valid_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_n;
      dirty_q <= dirty_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      vpn_q[vic_idx] <= fill_vpn;
      ppn_q[vic_idx] <= fill_ppn;
    end
  end

  // lookup answer, one register stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_pa    <= '0;
    end else begin
      rsp_valid <= lk_req;
      rsp_hit   <= hit_ev;
      rsp_miss  <= lk_req && !lk_any;
      rsp_pa    <= hit_ev ? join_pa(ppn_q[lk_idx], lk_va[OFS_W-1:0]) : '0;
    end
  end

  // eviction report, one register stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_valid <= 1'b0;
      ev_dirty <= 1'b0;
      ev_vpn   <= '0;
      ev_ppn   <= '0;
    end else begin
      ev_valid <= evict_ev;
      ev_dirty <= evict_ev && (dirty_q[vic_idx] || (wr_hit_ev && lk_idx == vic_idx));
      ev_vpn   <= evict_ev ? vpn_q[vic_idx] : '0;
      ev_ppn   <= evict_ev ? ppn_q[vic_idx] : '0;
    end
  end
endmodule

// File: rtl/xlat_buf_chk.sv
module xlat_buf_chk #(
  parameter int N = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         flush,
  input logic         fill_req,
  input logic         rsp_valid,
  input logic         rsp_hit,
  input logic         rsp_miss,
  input logic         ev_valid,
  input logic [N-1:0] valid_q,
  input logic [N-1:0] lk_vec
);
  // R2
  match_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_vec));

  // R3
  rsp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit != rsp_miss));

  // R2
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_miss));

  // R7
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));

  // R4
  free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && !flush && !(&valid_q)) |=> !ev_valid);

  // R5
  evict_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> ($past(fill_req && !flush) && $past(&valid_q)));
endmodule

bind xlat_buf xlat_buf_chk #(.N(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .fill_req(fill_req),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
  .ev_valid(ev_valid), .valid_q(valid_q), .lk_vec(lk_vec)
);

// File: tb/test_xlat_buf.sv
module test_xlat_buf;
  localparam int CLK_PERIOD = 10;
  localparam int NENT = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_req, lk_wr, fill_req, inv_req, flush;
  logic [31:0] lk_va;
  logic [21:0] fill_vpn, inv_vpn;
  logic [13:0] fill_ppn;
  logic        rsp_valid, rsp_hit, rsp_miss, ev_valid, ev_dirty;
  logic [23:0] rsp_pa;
  logic [21:0] ev_vpn;
  logic [13:0] ev_ppn;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  xlat_buf i_xlat_buf (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_wr(lk_wr), .lk_va(lk_va),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_pa(rsp_pa),
    .fill_req(fill_req), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .inv_req(inv_req), .inv_vpn(inv_vpn), .flush(flush),
    .ev_valid(ev_valid), .ev_dirty(ev_dirty), .ev_vpn(ev_vpn), .ev_ppn(ev_ppn)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_pa(input logic [13:0] ppn, input logic [9:0] ofs);
    return 32'(ppn) * 32'd1024 + 32'(ofs);
  endfunction

  task automatic idle();
    lk_req = 1'b0; lk_wr = 1'b0; lk_va = '0;
    fill_req = 1'b0; fill_vpn = '0; fill_ppn = '0;
    inv_req = 1'b0; inv_vpn = '0; flush = 1'b0;
  endtask

  // result of a lookup is sampled one rising edge after it is driven
  task automatic look(input logic [21:0] vpn, input logic [9:0] ofs, input logic wr,
                      input string req, input logic ehit, input logic [13:0] eppn);
    lk_req = 1'b1; lk_wr = wr; lk_va = {vpn, ofs};
    @(negedge clk); idle();
    chk(req, "rsp_valid", 32'(rsp_valid), 32'd1);
    chk(req, "rsp_hit",   32'(rsp_hit),   32'(ehit));
    chk(req, "rsp_miss",  32'(rsp_miss),  32'(!ehit));
    chk(req, "rsp_pa",    32'(rsp_pa),    ehit ? exp_pa(eppn, ofs) : 32'd0);
  endtask

  task automatic fill(input logic [21:0] vpn, input logic [13:0] ppn, input string req,
                      input logic eev, input logic edirty,
                      input logic [21:0] evpn, input logic [13:0] eppn);
    fill_req = 1'b1; fill_vpn = vpn; fill_ppn = ppn;
    @(negedge clk); idle();
    chk(req, "ev_valid", 32'(ev_valid), 32'(eev));
    if (eev) begin
      chk(req, "ev_dirty", 32'(ev_dirty), 32'(edirty));
      chk(req, "ev_vpn",   32'(ev_vpn),   32'(evpn));
      chk(req, "ev_ppn",   32'(ev_ppn),   32'(eppn));
    end
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    chk("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R1", "ev_valid after reset",  32'(ev_valid),  32'd0);
    look(22'h048D1, 10'h278, 1'b0, "R1", 1'b0, '0);
    look(22'h000000, 10'h000, 1'b1, "R1 R3", 1'b0, '0);
  endtask

  task automatic t_basic();
    fill(22'h0ABCD, 14'h1234, "R4", 1'b0, 1'b0, '0, '0);
    look(22'h0ABCD, 10'h3FF, 1'b0, "R2", 1'b1, 14'h1234);
    look(22'h0ABCD, 10'h000, 1'b1, "R2", 1'b1, 14'h1234);
    look(22'h0ABCE, 10'h155, 1'b0, "R3", 1'b0, '0);
  endtask

  task automatic t_same_cycle();
    fill_req = 1'b1; fill_vpn = 22'h00777; fill_ppn = 14'h0055;
    lk_req = 1'b1; lk_va = {22'h00777, 10'h0AA};
    @(negedge clk); idle();
    chk("R9", "lookup beside refill hit", 32'(rsp_hit), 32'd0);
    look(22'h00777, 10'h0AA, 1'b0, "R9", 1'b1, 14'h0055);
  endtask

  task automatic t_inval();
    inv_req = 1'b1; inv_vpn = 22'h3FFFFF;
    @(negedge clk); idle();
    look(22'h0ABCD, 10'h010, 1'b0, "R8 no-match", 1'b1, 14'h1234);
    look(22'h00777, 10'h020, 1'b0, "R8 no-match", 1'b1, 14'h0055);
    inv_req = 1'b1; inv_vpn = 22'h0ABCD;
    lk_req = 1'b1; lk_va = {22'h0ABCD, 10'h001};
    @(negedge clk); idle();
    chk("R9", "lookup beside invalidate hit", 32'(rsp_hit), 32'd1);
    look(22'h0ABCD, 10'h001, 1'b0, "R8", 1'b0, '0);
    look(22'h00777, 10'h002, 1'b0, "R8", 1'b1, 14'h0055);
  endtask

  task automatic t_flush();
    do_flush();
    look(22'h00777, 10'h0AA, 1'b0, "R7", 1'b0, '0);
    flush = 1'b1; fill_req = 1'b1; fill_vpn = 22'h00999; fill_ppn = 14'h0999;
    @(negedge clk); idle();
    look(22'h00999, 10'h000, 1'b0, "R7 priority", 1'b0, '0);
  endtask

  task automatic t_lru();
    do_flush();
    for (int i = 0; i < NENT; i++)
      fill(22'(32'h100 + i), 14'(32'h200 + i), "R4 free", 1'b0, 1'b0, '0, '0);
    look(22'h100, 10'h004, 1'b1, "R6 write", 1'b1, 14'h200);
    for (int i = 1; i < NENT; i++)
      look(22'(32'h100 + i), 10'h008, 1'b0, "R5 touch", 1'b1, 14'(32'h200 + i));
    fill(22'h800, 14'h300, "R5 R6 dirty victim", 1'b1, 1'b1, 22'h100, 14'h200);
    fill(22'h801, 14'h301, "R5 R6 clean victim", 1'b1, 1'b0, 22'h101, 14'h201);
    look(22'h100, 10'h004, 1'b0, "R5 evicted", 1'b0, '0);
    look(22'h800, 10'h004, 1'b0, "R4 loaded", 1'b1, 14'h300);
    inv_req = 1'b1; inv_vpn = 22'h120;
    @(negedge clk); idle();
    fill(22'h802, 14'h302, "R4 free slot reuse", 1'b0, 1'b0, '0, '0);
    fill(22'h803, 14'h303, "R5 next oldest", 1'b1, 1'b0, 22'h102, 14'h202);
    look(22'h802, 10'h3C0, 1'b0, "R4", 1'b1, 14'h302);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    rst_n = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_same_cycle();
    t_inval();
    t_flush();
    t_lru();
    done = 1'b1;
    report();
  end
endmodule